// File: doc/BRIEF.md
# Memory Card Command Channel Controller

This block is the command-path half of a host controller for an SD-style memory card. Software reaches it through a small register file of 32-bit words. A command goes out one byte at a time: software loads a byte, then pulses a start bit. The block shifts that byte onto the one-bit command line, changing it only as the card clock falls. A byte counter that runs modulo six tracks the six-byte command frame. Whenever the counter is at the head of a frame, the block forces the two header bits of the outgoing byte.

In the other direction, the block watches the command line on rising card-clock edges. It waits for a low start bit and then packs the incoming bits into bytes. Each finished byte can be read from the command register, and its arrival sets a receive pending flag that software clears by writing a one to it. A response is either six or seventeen bytes long, chosen by an enable bit. Once the last byte of a response has arrived, the receiver goes back to waiting for the next start bit. The card clock comes from the system clock through a programmable divider. A single interrupt line combines the pending flags with their enables.

Top module: `mcc_cmd_ctrl`

## Requirements
- R1: The enable register keeps its five low bits and reads them back, with all upper bits zero. The bits are: bit 0 command transmit, bit 1 command receive, bit 2 data transmit, bit 3 data receive, bit 4 long response.
- R2: After synchronous reset every register reads zero, cmd_out is 1, cmd_oe is 0 and card_clk is 0.
- R3: The card clock has a period of N = max(divider, 2) system cycles. A free-running count c = 0..N-1 makes card_clk go high after c = N/2-1 (integer division) and low after c = N-1.
- R4: A write of start bit 0 is accepted only while enable bit 0 is set and no byte is in flight. An accepted start shifts the held byte out most significant bit first, changing cmd_out only on falling card-clock edges, with cmd_oe high for eight card periods. A start written while the enable bit is clear, or while a byte is in flight, sends nothing.
- R5: The frame position counts sent bytes modulo 6. At position 0 the byte goes out as binary 01 followed by the six low bits that were written. At the other positions the byte goes out exactly as written. Only bits 7:0 of a command-register write are used.
- R6: Pending bit 0 is set when a byte has been fully sent and is cleared when the next transmit is accepted. Writing to pending bit 0 has no effect.
- R7: While enable bit 1 is set, a low cmd_in sampled on a rising card-clock edge is taken as a start bit and becomes bit 7 of the first byte. Every eight samples after that complete a byte. The byte can be read at the command register, and its arrival sets pending bit 1.
- R8: A response is 6 bytes long, or 17 bytes when enable bit 4 is set. After the last byte the receiver waits for a new start bit. Clearing enable bit 1 drops any partly received response.
- R9: Writing a one to pending bit 1 clears it. If a byte arrives in the same cycle, the set wins.
- R10: Pending bits 2 and 3 always read zero, and start bit 1 has no effect.
- R11: irq is the OR, across bits 0 to 3, of pending AND enable.
- R12: The word addresses are 0 enable, 1 pending, 2 start (reads zero), 3 command (reads the last received byte), 4 divider. Every other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| card_clk | output | 1 | Divided card clock |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line sampled value |

## Verification
The frame-position wrap is hard to reach from the ports: a header byte is forced only once every six transmitted bytes. The stimulus therefore sends seven complete bytes in a row, using a head byte whose top bits are deliberately wrong, so that both the first head and the wrapped head can be seen on the captured serial stream. Reaching the end of a long response is equally deep. The bench drives 136 bits onto cmd_in, each one aligned to a falling card-clock edge found by watching card_clk, with an odd divider in force. A behavioural reference model runs in step with the design and checks the line and register outputs on every cycle.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 3;
    localparam int FRAME_BYTES = 6;
    localparam int SHORT_RESP  = 6;
    localparam int LONG_RESP   = 17;

    // enable / pending bit positions
    localparam int EN_CTX  = 0;
    localparam int EN_CRX  = 1;
    localparam int EN_DTX  = 2;
    localparam int EN_DRX  = 3;
    localparam int EN_LONG = 4;
    localparam int EN_W    = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_ENABLE  = 3'd0,
        A_PENDING = 3'd1,
        A_START   = 3'd2,
        A_CMD     = 3'd3,
        A_DIV     = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic drx;
        logic dtx;
        logic crx;
        logic ctx;
    } pend_t;

    // head byte of a frame carries the 01 header above the index
    function automatic logic [7:0] frame_byte(input logic [7:0] b, input logic head);
        return head ? {2'b01, b[5:0]} : b;
    endfunction

endpackage

// File: rtl/mcc_clkgen.sv
module mcc_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             rise_tick,
    output logic             fall_tick,
    output logic             card_clk
);
    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;
    logic             armed;

    always_comb begin
        ratio     = (div < DIV_W'(2)) ? DIV_W'(2) : div;
        half      = ratio >> 1;
        rise_tick = (cnt == half - 1'b1);
        fall_tick = (cnt >= ratio - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            card_clk <= 1'b0;
            armed    <= 1'b0;
        end else begin
            armed <= 1'b1;
            cnt   <= fall_tick ? '0 : cnt + 1'b1;
            if (fall_tick)      card_clk <= 1'b0;
            else if (rise_tick) card_clk <= 1'b1;
        end
    end

    // R3: with a ratio of at least two the edges never coincide
    p_ticks_apart_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        rise_tick |-> !fall_tick);

endmodule

// File: rtl/mcc_cmd_tx.sv
module mcc_cmd_tx
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] byte_in,
    input  logic       fall_tick,
    output logic       busy,
    output logic       done,
    output logic       cmd_out,
    output logic       cmd_oe
);
    localparam int PTR_W = $clog2(FRAME_BYTES);

    logic [7:0]       shreg;
    logic [3:0]       nbits;
    logic [PTR_W-1:0] pos;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            shreg   <= '0;
            nbits   <= '0;
            pos     <= '0;
            cmd_out <= 1'b1;
            cmd_oe  <= 1'b0;
            armed   <= 1'b0;
        end else begin
            armed <= 1'b1;
            done  <= 1'b0;
            if (go) begin
                busy  <= 1'b1;
                shreg <= frame_byte(byte_in, pos == '0);
                nbits <= '0;
            end else if (busy && fall_tick) begin
                if (nbits != 4'd8) begin
                    cmd_out <= shreg[7];
                    cmd_oe  <= 1'b1;
                    shreg   <= {shreg[6:0], 1'b0};
                    nbits   <= nbits + 1'b1;
                end else begin
                    busy    <= 1'b0;
                    cmd_oe  <= 1'b0;
                    cmd_out <= 1'b1;
                    done    <= 1'b1;
                    pos     <= (pos == PTR_W'(FRAME_BYTES - 1)) ? '0 : pos + 1'b1;
                end
            end
        end
    end

    // R4: the line holds its value between falling card edges
    p_line_holds_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        (busy && !fall_tick && !go) |=> $stable(cmd_out));

endmodule

// File: rtl/mcc_cmd_rx.sv
module mcc_cmd_rx
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       long_mode,
    input  logic       rise_tick,
    input  logic       cmd_in,
    output logic [7:0] byte_out,
    output logic       byte_valid
);
    localparam int CNT_W = $clog2(LONG_RESP);

    logic             active;
    logic [7:0]       shreg;
    logic [2:0]       nbits;
    logic [CNT_W-1:0] nbytes;
    logic [CNT_W-1:0] last;
    logic             armed;

    assign last = long_mode ? CNT_W'(LONG_RESP - 1) : CNT_W'(SHORT_RESP - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            shreg      <= '0;
            nbits      <= '0;
            nbytes     <= '0;
            byte_out   <= '0;
            byte_valid <= 1'b0;
            armed      <= 1'b0;
        end else begin
            armed      <= 1'b1;
            byte_valid <= 1'b0;
            if (!enable) begin
                active <= 1'b0;
                nbits  <= '0;
                nbytes <= '0;
            end else if (rise_tick) begin
                if (!active) begin
                    if (!cmd_in) begin
                        active <= 1'b1;
                        shreg  <= '0;
                        nbits  <= 3'd1;
                    end
                end else begin
                    shreg <= {shreg[6:0], cmd_in};
                    nbits <= nbits + 1'b1;
                    if (nbits == 3'd7) begin
                        byte_out   <= {shreg[6:0], cmd_in};
                        byte_valid <= 1'b1;
                        if (nbytes == last) begin
                            active <= 1'b0;
                            nbytes <= '0;
                        end else begin
                            nbytes <= nbytes + 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R7: a completed byte always follows a rising card edge
    p_byte_on_rise_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        byte_valid |-> $past(rise_tick));

endmodule

// File: rtl/mcc_cmd_ctrl.sv
module mcc_cmd_ctrl
    import mcc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic              card_clk,
    output logic              cmd_out,
    output logic              cmd_oe,
    input  logic              cmd_in
);
    logic [EN_W-1:0]  en_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       hold_q;
    logic             pend_tx;
    logic             pend_rx;
    pend_t            pend;
    logic             rise_tick, fall_tick;
    logic             tx_busy, tx_done, tx_go;
    logic [7:0]       rx_byte;
    logic             rx_valid;
    logic             wr_en, wr_pend, wr_start, wr_cmd, wr_div;
    logic             armed;

    always_comb begin
        wr_en    = reg_we && (reg_addr_e'(reg_addr) == A_ENABLE);
        wr_pend  = reg_we && (reg_addr_e'(reg_addr) == A_PENDING);
        wr_start = reg_we && (reg_addr_e'(reg_addr) == A_START);
        wr_cmd   = reg_we && (reg_addr_e'(reg_addr) == A_CMD);
        wr_div   = reg_we && (reg_addr_e'(reg_addr) == A_DIV);
        tx_go    = wr_start && reg_wdata[0] && en_q[EN_CTX] && !tx_busy;
    end

    mcc_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .div       (div_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .card_clk  (card_clk)
    );

    mcc_cmd_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .go        (tx_go),
        .byte_in   (hold_q),
        .fall_tick (fall_tick),
        .busy      (tx_busy),
        .done      (tx_done),
        .cmd_out   (cmd_out),
        .cmd_oe    (cmd_oe)
    );

    mcc_cmd_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .enable     (en_q[EN_CRX]),
        .long_mode  (en_q[EN_LONG]),
        .rise_tick  (rise_tick),
        .cmd_in     (cmd_in),
        .byte_out   (rx_byte),
        .byte_valid (rx_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            div_q   <= '0;
            hold_q  <= '0;
            pend_tx <= 1'b0;
            pend_rx <= 1'b0;
            armed   <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (wr_en)  en_q   <= reg_wdata[EN_W-1:0];
            if (wr_div) div_q  <= reg_wdata[DIV_W-1:0];
            if (wr_cmd) hold_q <= reg_wdata[7:0];
            if (tx_go)        pend_tx <= 1'b0;
            else if (tx_done) pend_tx <= 1'b1;
            if (rx_valid)                         pend_rx <= 1'b1;
            else if (wr_pend && reg_wdata[EN_CRX]) pend_rx <= 1'b0;
        end
    end

    always_comb begin
        pend = '{drx: 1'b0, dtx: 1'b0, crx: pend_rx, ctx: pend_tx};
        irq  = |(pend & en_q[3:0]);
        case (reg_addr_e'(reg_addr))
            A_ENABLE:  reg_rdata = WORD_W'(en_q);
            A_PENDING: reg_rdata = WORD_W'(pend);
            A_CMD:     reg_rdata = WORD_W'(rx_byte);
            A_DIV:     reg_rdata = WORD_W'(div_q);
            default:   reg_rdata = '0;
        endcase
    end

    // R9: clearing receive pending takes effect unless a byte lands
    p_rx_clear_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_pend && reg_wdata[EN_CRX] && !rx_valid) |=> !pend_rx);

    // R6: transmit pending is only ever seen with the shifter idle
    p_txpend_idle_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        pend_tx |-> !tx_busy);

    // R11: no interrupt without some enable bit
    p_irq_gated_r11: assert property (@(posedge clk) disable iff (rst || !armed)
        irq |-> (en_q[3:0] != 4'd0));

endmodule

// File: tb/tb_mcc_cmd_ctrl.sv
module tb_mcc_cmd_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, card_clk, cmd_out, cmd_oe;
    logic        cmd_in = 1'b1;

    always #4 clk = ~clk;

    mcc_cmd_ctrl dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .card_clk(card_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
    );

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit         model_on = 0;
    logic [4:0] m_en;
    int         m_div, m_cnt, m_ptr, m_rcnt;
    logic [7:0] m_hold, m_rbyte;
    bit         m_ptx, m_prx, m_busy, m_done, m_rxv, m_ract, m_cclk, m_out, m_oe;
    bit         txq[$];
    bit         rxq[$];
    int         ratio;
    bit         rise, fall, go;
    logic [7:0] mb;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_div = 0; m_cnt = 0; m_ptr = 0; m_rcnt = 0;
            m_hold = 0; m_rbyte = 0; m_ptx = 0; m_prx = 0; m_busy = 0;
            m_done = 0; m_rxv = 0; m_ract = 0; m_cclk = 0; m_out = 1; m_oe = 0;
            txq.delete(); rxq.delete();
            model_on = 1;
        end else if (model_on) begin
            ratio = (m_div < 2) ? 2 : m_div;
            rise  = (m_cnt == ratio / 2 - 1);
            fall  = (m_cnt >= ratio - 1);
            go    = reg_we && reg_addr == 3'd2 && reg_wdata[0] && m_en[0] && !m_busy;
            if (go) m_ptx = 0; else if (m_done) m_ptx = 1;
            if (m_rxv) m_prx = 1;
            else if (reg_we && reg_addr == 3'd1 && reg_wdata[1]) m_prx = 0;
            m_done = 0;
            if (go) begin
                mb = m_hold;
                if (m_ptr == 0) mb = {2'b01, mb[5:0]};
                m_busy = 1;
                txq.delete();
                for (int i = 7; i >= 0; i--) txq.push_back(mb[i]);
            end else if (m_busy && fall) begin
                if (txq.size() > 0) begin
                    m_out = txq.pop_front();
                    m_oe  = 1;
                end else begin
                    m_busy = 0; m_oe = 0; m_out = 1; m_done = 1;
                    m_ptr = (m_ptr + 1) % 6;
                end
            end
            m_rxv = 0;
            if (!m_en[1]) begin
                m_ract = 0; m_rcnt = 0; rxq.delete();
            end else if (rise) begin
                if (!m_ract) begin
                    if (cmd_in == 1'b0) begin
                        m_ract = 1; rxq.delete(); rxq.push_back(1'b0);
                    end
                end else begin
                    rxq.push_back(cmd_in);
                    if (rxq.size() == 8) begin
                        mb = 0;
                        foreach (rxq[i]) mb = {mb[6:0], rxq[i]};
                        m_rbyte = mb; m_rxv = 1; rxq.delete();
                        if (m_rcnt == (m_en[4] ? 16 : 5)) begin
                            m_ract = 0; m_rcnt = 0;
                        end else m_rcnt++;
                    end
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_en   = reg_wdata[4:0];
                    3'd3: m_hold = reg_wdata[7:0];
                    3'd4: m_div  = int'(reg_wdata[7:0]);
                    default: ;
                endcase
            end
            if (fall) m_cclk = 0; else if (rise) m_cclk = 1;
            m_cnt = fall ? 0 : m_cnt + 1;
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return {27'd0, m_en};
            3'd1: return {30'd0, m_prx, m_ptx};
            3'd3: return {24'd0, m_rbyte};
            3'd4: return 32'(m_div);
            default: return 32'd0;
        endcase
    endfunction

    // per-cycle comparison and serial capture, away from the active edge
    bit cap[$];
    bit prev_cclk = 0;
    always @(negedge clk) begin
        if (model_on && !rst && !done_flag) begin
            chk("R3 card_clk", {31'd0, card_clk}, {31'd0, m_cclk});
            chk("R4 cmd_out", {31'd0, cmd_out}, {31'd0, m_out});
            chk("R4 cmd_oe", {31'd0, cmd_oe}, {31'd0, m_oe});
            chk("R11 irq", {31'd0, irq}, {31'd0, |({2'b00, m_prx, m_ptx} & m_en[3:0])});
            chk("R12 rdata", reg_rdata, exp_rdata(reg_addr));
            if (card_clk && !prev_cclk && cmd_oe) cap.push_back(cmd_out);
            prev_cclk = card_clk;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        chk(req, reg_rdata, exp);
    endtask

    task automatic wait_tx();
        @(posedge clk); #1;
        reg_addr = 3'd1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (reg_rdata[0]) break;
        end
    endtask

    task automatic send_tx(input logic [31:0] d);
        wr(3'd3, d);
        wr(3'd2, 32'd1);
        wait_tx();
    endtask

    task automatic take_byte(input logic [7:0] exp, input string req);
        logic [7:0] b = 8'd0;
        if (cap.size() < 8) begin
            chk(req, 32'(cap.size()), 32'd8);
        end else begin
            for (int i = 0; i < 8; i++) b = {b[6:0], cap.pop_front()};
            chk(req, {24'd0, b}, {24'd0, exp});
        end
    endtask

    task automatic wait_cfall();
        logic last = card_clk;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk); #1;
            if (last && !card_clk) break;
            last = card_clk;
        end
    endtask

    task automatic rx_send(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_cfall();
            cmd_in = b[i];
        end
    endtask

    task automatic rx_idle(input int n);
        for (int i = 0; i < n; i++) begin
            wait_cfall();
            cmd_in = 1'b1;
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R2 cmd_out after reset", {31'd0, cmd_out}, 32'd1);
        chk("R2 cmd_oe after reset", {31'd0, cmd_oe}, 32'd0);
        rd_chk(3'd0, 32'd0, "R2 enable");
        rd_chk(3'd1, 32'd0, "R2 pending");
        rd_chk(3'd3, 32'd0, "R2 command");
        rd_chk(3'd4, 32'd0, "R2 divider");

        // R1 / R12 register map
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk(3'd0, 32'h1F, "R1 enable readback");
        rd_chk(3'd2, 32'd0, "R12 start reads zero");
        rd_chk(3'd7, 32'd0, "R12 unmapped address");
        wr(3'd0, 32'd0);

        // R10 data pending bits and data start
        wr(3'd0, 32'hC);
        wr(3'd1, 32'hF);
        wr(3'd2, 32'h2);
        repeat (20) @(posedge clk);
        rd_chk(3'd1, 32'd0, "R10 data pending stays zero");
        chk("R10 no drive after data start", {31'd0, cmd_oe}, 32'd0);
        chk("R11 irq low with no pending", {31'd0, irq}, 32'd0);

        // R3 divider settings
        wr(3'd4, 32'd1);
        rd_chk(3'd4, 32'd1, "R3 divider readback");
        repeat (12) @(posedge clk);
        wr(3'd4, 32'd5);
        repeat (30) @(posedge clk);
        wr(3'd4, 32'd4);

        // R4 / R5 transmit a whole frame plus the wrapped head
        wr(3'd0, 32'd1);
        cap.delete();
        send_tx(32'hD1);
        take_byte(8'h51, "R5 head byte forced header");
        chk("R11 irq on tx pending", {31'd0, irq}, 32'd1);
        send_tx(32'hA5);
        take_byte(8'hA5, "R4 msb first");
        send_tx(32'h00);
        send_tx(32'hFF);
        send_tx(32'h3C);
        send_tx(32'h2B);
        take_byte(8'h00, "R5 body byte");
        take_byte(8'hFF, "R5 body byte");
        take_byte(8'h3C, "R5 body byte");
        take_byte(8'h2B, "R5 last body byte");
        send_tx(32'hFF);
        take_byte(8'h7F, "R5 wrapped head byte");
        send_tx(32'h1234_56C3);
        take_byte(8'hC3, "R5 low eight bits only");

        // R6 pending bit 0
        rd_chk(3'd1, 32'd1, "R6 tx pending set");
        wr(3'd1, 32'd1);
        rd_chk(3'd1, 32'd1, "R6 tx pending write ignored");
        wr(3'd3, 32'h96);
        wr(3'd2, 32'd1);
        rd_chk(3'd1, 32'd0, "R6 tx pending cleared on start");
        wr(3'd2, 32'd1);
        wait_tx();
        repeat (40) @(posedge clk);
        take_byte(8'h96, "R4 byte sent once");
        chk("R4 busy start ignored", 32'(cap.size()), 32'd0);
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd1);
        repeat (60) @(posedge clk);
        chk("R4 start ignored when disabled", 32'(cap.size()), 32'd0);
        rd_chk(3'd1, 32'd1, "R4 pending untouched when disabled");

        // R7 / R8 short response with odd divider
        wr(3'd4, 32'd3);
        wr(3'd0, 32'd2);
        @(posedge clk); #1 reg_addr = 3'd3;
        rx_idle(5);
        rx_send(8'h11); rx_send(8'h00); rx_send(8'h00);
        rx_send(8'h09); rx_send(8'h00); rx_send(8'h91);
        rx_idle(3);
        rd_chk(3'd3, 32'h91, "R7 last response byte");
        rd_chk(3'd1, 32'd3, "R7 rx pending set");
        chk("R11 irq on rx pending", {31'd0, irq}, 32'd1);

        // R9 write-one-to-clear
        wr(3'd1, 32'd1);
        rd_chk(3'd1, 32'd3, "R9 bit0 write leaves rx pending");
        wr(3'd1, 32'd2);
        rd_chk(3'd1, 32'd1, "R9 rx pending cleared");

        // R8 receiver idles after a short response
        @(posedge clk); #1 reg_addr = 3'd3;
        rx_idle(20);
        rd_chk(3'd1, 32'd1, "R8 no byte while idle");

        // R8 long response
        wr(3'd0, 32'h12);
        @(posedge clk); #1 reg_addr = 3'd3;
        rx_send(8'h3F);
        for (int i = 1; i < 17; i++) rx_send(8'(i * 13));
        rx_idle(3);
        rd_chk(3'd3, 32'hD0, "R8 seventeenth byte");
        wr(3'd1, 32'd2);
        rx_idle(12);
        rd_chk(3'd1, 32'd1, "R8 long response ended");

        // R8 partial response dropped on disable
        rx_send(8'h0F);
        wr(3'd0, 32'd0);
        wr(3'd0, 32'd2);
        @(posedge clk); #1 reg_addr = 3'd3;
        rx_idle(2);
        rx_send(8'h05);
        rx_idle(3);
        rd_chk(3'd3, 32'h05, "R8 restart after disable");

        // R11 irq gated by enable
        wr(3'd0, 32'd0);
        rd_chk(3'd1, 32'd3, "R11 pending kept");
        chk("R11 irq gated off", {31'd0, irq}, 32'd0);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule